// File: doc/BRIEF.md
# Truncated Fixed-Width Approximate Multiplier

This block multiplies two unsigned N-bit operands and returns an N-bit result equal to the upper half of an approximated 2N-bit product. The approximation is set per operation. Every partial product whose column index (i + j for operand-A bit j and operand-B bit i) is below a chosen cut column is thrown away. A chosen number of columns directly at and above the cut form their partial products with OR instead of AND. All higher columns are exact. When enabled, a rounding constant is added back to offset the downward bias left by the discarded columns. It is used where a full-precision product is not needed and the operation can trade accuracy in low-order columns for less logic.

Operations enter and leave on valid/ready streams. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its operands and all three control fields are captured together at that edge. A result is handed over on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high exactly when the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is accepted. The pipeline is two registers deep: reduction of the partial products, then the final add with the compensation term.

Top module: `apx_trunc_mult`

## Requirements
- R1: With cut column 0, OR-band width 0 and compensation off, `out_data` equals bits [2N-1:N] of the exact product `in_a * in_b`.
- R2: Partial products in every column c with c < `in_trunc_col` contribute nothing to the result.
- R3: A partial product in a column c with `in_trunc_col` <= c < `in_trunc_col + in_or_width` equals `in_a[j] | in_b[i]`. The sum `in_trunc_col + in_or_width` is taken without wrap-around.
- R4: A partial product in a column c >= `in_trunc_col + in_or_width` equals `in_a[j] & in_b[i]` and is summed exactly.
- R5: When `in_comp_en` is 1, the sum gains 2^(T-2) for cut column T >= 2, gains 1 for T = 1, and gains 0 for T = 0. When `in_comp_en` is 0, nothing is added. The result is bits [2N-1:N] of that total.
- R6: With `out_ready` held high, an operation accepted at clock edge k appears with `out_valid` high after edge k+2, and `out_valid` is low after edge k+1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_data` stays stable, and `in_ready` is 0.
- R8: `in_ready` is 1 whenever `out_valid` is 0. Operands and control fields are sampled only at acceptance, so later changes do not alter an accepted operation's result.
- R9: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R10: Results leave in acceptance order. No result appears without a matching accepted operation, and at most two operations are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_a | input | N | Multiplicand |
| in_b | input | N | Multiplier |
| in_trunc_col | input | CW | First kept column (CW = clog2(2N)) |
| in_or_width | input | CW | Number of OR columns starting at the cut |
| in_comp_en | input | 1 | Add the bias compensation constant |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N | Upper N bits of the approximated product |

## Verification
The main function is driven with several operand patterns. All-ones operands make the OR and AND rules agree, so any difference from the exact product there must come from the cut or the compensation. Zero against all-ones operands make every OR product 1 and every AND product 0, so they show exactly which columns belong to the OR band and where it ends. Single-bit operands place one partial product in a known column, which tells whether that column was dropped or kept, and which compensation constant was applied. Random operands with random control fields, accepted under random back-pressure, are checked against an independent column-by-column model, which also checks ordering and hold behaviour.

// File: rtl/apx_mult_pkg.sv
package apx_mult_pkg;

  typedef enum logic [1:0] {
    COL_DROP = 2'd0,
    COL_OR   = 2'd1,
    COL_AND  = 2'd2
  } col_kind_e;

  // Classify one product column against the cut and the OR band.
  function automatic col_kind_e col_kind(input int col, input int cut, input int band);
    if (col < cut)
      return COL_DROP;
    else if (col < cut + band)
      return COL_OR;
    else
      return COL_AND;
  endfunction

endpackage

// File: rtl/apx_col_ctrl.sv
module apx_col_ctrl
  import apx_mult_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = $clog2(2 * N)
) (
  input  logic [CW-1:0]  cut_col,
  input  logic [CW-1:0]  or_width,
  output logic [2*N-2:0] keep_mask,
  output logic [2*N-2:0] or_mask
);
  localparam int COLS = 2 * N - 1;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    col_kind_e kind;
    always_comb begin
      kind         = col_kind(c, int'(cut_col), int'(or_width));
      keep_mask[c] = (kind != COL_DROP);
      or_mask[c]   = (kind == COL_OR);
    end
  end
endmodule

// File: rtl/apx_pp_array.sv
module apx_pp_array #(
  parameter int N = 8
) (
  input  logic [N-1:0]            opa,
  input  logic [N-1:0]            opb,
  input  logic [2*N-2:0]          keep_mask,
  input  logic [2*N-2:0]          or_mask,
  output logic [N-1:0][2*N-1:0]   rows
);
  localparam int PW = 2 * N;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar p = 0; p < PW; p++) begin : g_bit
      if (p < i || p > i + N - 1) begin : g_zero
        assign rows[i][p] = 1'b0;
      end else begin : g_pp
        assign rows[i][p] = keep_mask[p] &
                            (or_mask[p] ? (opa[p-i] | opb[i]) : (opa[p-i] & opb[i]));
      end
    end
  end
endmodule

// File: rtl/apx_row_sum.sv
module apx_row_sum #(
  parameter int N  = 8,
  parameter int SW = 2 * N + 1
) (
  input  logic [N-1:0][2*N-1:0] rows,
  output logic [SW-1:0]         total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + SW'(rows[i]);
    end
  end
endmodule

// File: rtl/apx_comp_gen.sv
module apx_comp_gen #(
  parameter int N  = 8,
  parameter int CW = $clog2(2 * N),
  parameter int SW = 2 * N + 1
) (
  input  logic [CW-1:0] cut_col,
  input  logic          enable,
  output logic [SW-1:0] comp
);
  always_comb begin
    comp = '0;
    if (enable) begin
      if (cut_col >= CW'(2))
        comp = SW'(1) << (cut_col - CW'(2));
      else if (cut_col == CW'(1))
        comp = SW'(1);
    end
  end
endmodule

// File: rtl/apx_trunc_mult.sv
module apx_trunc_mult #(
  parameter int N  = 8,
  parameter int CW = $clog2(2 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_a,
  input  logic [N-1:0]  in_b,
  input  logic [CW-1:0] in_trunc_col,
  input  logic [CW-1:0] in_or_width,
  input  logic          in_comp_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N-1:0]  out_data
);
  localparam int SW = 2 * N + 1;

  logic                 advance;
  logic [2*N-2:0]       keep_mask;
  logic [2*N-2:0]       or_mask;
  logic [N-1:0][2*N-1:0] rows;
  logic [SW-1:0]        pp_total;
  logic [SW-1:0]        comp;

  logic                 s1_valid;
  logic [SW-1:0]        s1_total;
  logic [SW-1:0]        s1_comp;
  logic [SW-1:0]        final_sum;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  apx_col_ctrl #(.N(N), .CW(CW)) u_col_ctrl (
    .cut_col   (in_trunc_col),
    .or_width  (in_or_width),
    .keep_mask (keep_mask),
    .or_mask   (or_mask)
  );

  apx_pp_array #(.N(N)) u_pp_array (
    .opa       (in_a),
    .opb       (in_b),
    .keep_mask (keep_mask),
    .or_mask   (or_mask),
    .rows      (rows)
  );

  apx_row_sum #(.N(N), .SW(SW)) u_row_sum (
    .rows  (rows),
    .total (pp_total)
  );

  apx_comp_gen #(.N(N), .CW(CW), .SW(SW)) u_comp_gen (
    .cut_col (in_trunc_col),
    .enable  (in_comp_en),
    .comp    (comp)
  );

  // Stage 1: reduced partial-product sum and compensation constant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_total <= '0;
      s1_comp  <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_total <= pp_total;
        s1_comp  <= comp;
      end
    end
  end

  assign final_sum = s1_total + s1_comp;

  // Stage 2: final add and upper-half selection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid)
        out_data <= final_sum[2*N-1:N];
    end
  end
endmodule

// File: rtl/apx_trunc_mult_chk.sv
module apx_trunc_mult_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_data
);
  logic [1:0] inflight;
  logic       in_fire;
  logic       out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      inflight <= '0;
    else
      inflight <= inflight + {1'b0, in_fire} - {1'b0, out_fire};
  end

  a_r6_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_fire, 2) && $past(in_ready) |-> out_valid);

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r7_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 2'd2);

  a_r10_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 2'd0);
endmodule

bind apx_trunc_mult apx_trunc_mult_chk #(.N(N)) u_apx_trunc_mult_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_apx_trunc_mult.sv
module test_apx_trunc_mult;
  localparam int N  = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_a = '0;
  logic [N-1:0]  in_b = '0;
  logic [CW-1:0] in_trunc_col = '0;
  logic [CW-1:0] in_or_width = '0;
  logic          in_comp_en = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [N-1:0]  out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  apx_trunc_mult #(.N(N), .CW(CW)) i_apx_trunc_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_trunc_col(in_trunc_col), .in_or_width(in_or_width),
    .in_comp_en(in_comp_en), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] cut;
    logic [3:0] band;
    logic       comp;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd255, 8'd255, 4'd0,  4'd0,  1'b0, 8'hFE},  // R1
    '{8'd200, 8'd100, 4'd0,  4'd0,  1'b0, 8'h4E},  // R1
    '{8'd128, 8'd2,   4'd0,  4'd0,  1'b0, 8'h01},  // R1
    '{8'd255, 8'd1,   4'd0,  4'd0,  1'b0, 8'h00},  // R1
    '{8'd0,   8'd255, 4'd0,  4'd15, 1'b0, 8'hFE},  // R3 whole array ORed
    '{8'd0,   8'd255, 4'd8,  4'd1,  1'b0, 8'h07},  // R3 column 8 only, R4 column 9 exact
    '{8'd0,   8'd255, 4'd8,  4'd2,  1'b0, 8'h13},  // R3 columns 8 and 9
    '{8'd0,   8'd255, 4'd14, 4'd15, 1'b0, 8'h40},  // R3 band clipped at top column
    '{8'd255, 8'd255, 4'd0,  4'd7,  1'b0, 8'hFE},  // R4 upper columns exact
    '{8'd255, 8'd255, 4'd15, 4'd0,  1'b0, 8'h00},  // R2 all columns dropped
    '{8'd16,  8'd16,  4'd8,  4'd0,  1'b0, 8'h01},  // R2 column 8 kept
    '{8'd16,  8'd16,  4'd9,  4'd0,  1'b0, 8'h00},  // R2 column 8 dropped
    '{8'd255, 8'd255, 4'd15, 4'd0,  1'b1, 8'h20},  // R5 2^13
    '{8'd0,   8'd0,   4'd10, 4'd0,  1'b1, 8'h01},  // R5 2^8
    '{8'd0,   8'd0,   4'd9,  4'd0,  1'b1, 8'h00},  // R5 2^7
    '{8'd16,  8'd16,  4'd10, 4'd0,  1'b1, 8'h01},  // R5 with column 8 dropped
    '{8'd0,   8'd0,   4'd1,  4'd0,  1'b1, 8'h00}   // R5 cut 1 adds 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Column-by-column model written from the requirements.
  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input int cut, input int band, input logic comp);
    int sum = 0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int col = i + j;
        int bitv;
        if (col < cut) bitv = 0;
        else if (col < cut + band) bitv = int'(a[j] | b[i]);
        else bitv = int'(a[j] & b[i]);
        sum += bitv << col;
      end
    end
    if (comp) begin
      if (cut >= 2) sum += 1 << (cut - 2);
      else if (cut == 1) sum += 1;
    end
    return sum[15:8];
  endfunction

  task automatic send_one(input vec_t v, input string req);
    @(negedge clk);
    in_a = v.a; in_b = v.b; in_trunc_col = v.cut; in_or_width = v.band; in_comp_en = v.comp;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 not valid after one edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R6 valid after two edges", {31'd0, out_valid}, 32'd1);
    check(req, {24'd0, out_data}, {24'd0, v.exp});
  endtask

  logic [7:0] expq [0:1023];
  int wr = 0;
  int rd = 0;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R8 in_ready when empty", {31'd0, in_ready}, 32'd1);

    for (int k = 0; k < NV; k++) begin
      send_one(VECS[k], "R1..R5 table vector");
      check("table vector vs model", {24'd0, VECS[k].exp},
            {24'd0, model(VECS[k].a, VECS[k].b, VECS[k].cut, VECS[k].band, VECS[k].comp)});
    end

    // R8: controls sampled only at acceptance
    @(negedge clk);
    in_a = 8'd255; in_b = 8'd255; in_trunc_col = 4'd15; in_or_width = 4'd0; in_comp_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_trunc_col = 4'd0; in_comp_en = 1'b1;
    @(negedge clk);
    check("R8 late control change ignored", {24'd0, out_data}, 32'd0);

    // R7 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_trunc_col = 4'd0; in_or_width = 4'd0; in_comp_en = 1'b0;
    in_a = 8'd200; in_b = 8'd100; in_valid = 1'b1;           // A -> 0x4E
    @(negedge clk);
    in_a = 8'd255; in_b = 8'd255;                            // B -> 0xFE
    check("R8 ready while output empty", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_a = 8'd128; in_b = 8'd2;                              // C -> 0x01
    check("R7 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    check("R7 stalled data A", {24'd0, out_data}, 32'h4E);
    repeat (2) @(negedge clk);
    check("R7 valid held", {31'd0, out_valid}, 32'd1);
    check("R7 data held", {24'd0, out_data}, 32'h4E);
    check("R7 still not ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1;
    check("R8 ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 order second B", {24'd0, out_data}, 32'hFE);
    @(negedge clk);
    check("R10 order third C", {24'd0, out_data}, 32'h01);
    @(negedge clk);
    check("R6 drained", {31'd0, out_valid}, 32'd0);

    // Random stream with random back-pressure, R1..R5 and R10 against the model
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      in_valid     = ($urandom_range(0, 3) != 0) && (cyc < 2980);
      out_ready    = ($urandom_range(0, 3) != 0) || (cyc >= 2980);
      in_a         = 8'($urandom);
      in_b         = 8'($urandom);
      in_trunc_col = 4'($urandom_range(0, 15));
      in_or_width  = ($urandom_range(0, 1) != 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      in_comp_en   = 1'($urandom);
      if (cyc % 7 == 0) begin in_trunc_col = 4'd0; in_or_width = 4'd0; in_comp_en = 1'b0; end
      #1;
      if (out_valid && out_ready) begin
        check("R10 random result vs model", {24'd0, out_data}, {24'd0, expq[rd % 1024]});
        rd++;
      end
      if (in_valid && in_ready) begin
        expq[wr % 1024] = model(in_a, in_b, int'(in_trunc_col), int'(in_or_width), in_comp_en);
        wr++;
      end
    end
    check("R10 all accepted results delivered", rd, wr);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule